// File: doc/BRIEF.md
# Video Timing Event Interrupt Controller

This block watches a display pipeline's active-area strobe (DE) and vertical sync (VSYNC), both already corrected to active-high, and an asynchronous tearing-effect input from a panel. It turns six kinds of event into sticky status flags: rising and falling edges of VSYNC, rising and falling edges of DE, end of frame, and a tearing-effect pulse. It raises one interrupt line whenever an enabled flag is set.

Software reaches it through a single 32-bit register with a write strobe and a read port that always shows the current value. The low half of the word holds one enable bit per source. The high half holds the status flags. A status flag is cleared by writing 1 to it, and writing 0 leaves it alone. Each write also loads the enable field, so software sends back the enables it wants to keep in the same word.

End of frame is found by counting DE falling edges from the last VSYNC rising edge, or from reset if no VSYNC edge has come yet. The fall that completes line number `ACTIVE_LINES` is the end of the frame.

Top module: `vtev_irq_ctrl`

## Requirements
- R1: After reset every bit of `reg_rdata` is 0 and `irq_o` is 0.
- R2: A write loads `reg_wdata[5:0]` into the enable field, which reads back on `reg_rdata[5:0]`. Bits 15:6 and 31:22 of `reg_rdata` always read 0, whatever was written there. Enable bit n belongs to status bit 16+n.
- R3: A VSYNC rising edge sets status bit 17 and a VSYNC falling edge sets status bit 18. The flag is visible on `reg_rdata` after the first clock edge at which the new level is sampled.
- R4: A DE rising edge sets status bit 19 and a DE falling edge sets status bit 20, with the same timing as R3.
- R5: End of frame sets status bit 21 on the DE falling edge that ends line number `ACTIVE_LINES`, counted since the latest VSYNC rising edge. Earlier falls in the frame do not set it, and neither do later falls before the next VSYNC rise.
- R6: The tearing-effect input passes through two synchronising flops. Its rising edge sets status bit 16, which is visible after the third clock edge from the change at the pin.
- R7: Status flags latch whether or not their enable is set.
- R8: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. Without a write, a set flag stays set.
- R9: If an event and a write-1 clear reach the same status bit in the same cycle, the bit stays set.
- R10: `irq_o` is 1 exactly when some status bit 16+n and enable bit n are both 1.
- R11: Only edges set flags. An input held at a steady level does not set a flag again after that flag has been cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| vid_de | input | 1 | Active-area strobe, active high, synchronous to clk |
| vid_vs | input | 1 | Vertical sync, active high, synchronous to clk |
| te_async | input | 1 | Tearing-effect input, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Current register value |
| irq_o | output | 1 | Interrupt request, level |

## Verification
The hardest case to reach is R9, where a write-1 clear and a new edge land on the same flag in one cycle. The bench first sets the DE flags. It then raises DE on the same falling clock edge that presents a write clearing both DE flags. The rise flag must survive the write and the fall flag must go. End of frame is reached by driving whole frames of a VSYNC pulse followed by DE lines, with `ACTIVE_LINES` set to 2. The interrupt logic is swept over all 64 clear masks, each paired with a different enable pattern, after every source has been fired.

// File: rtl/vtev_pkg.sv
package vtev_pkg;

    localparam int NSRC     = 6;
    localparam int STAT_LSB = 16;
    localparam int WORD_W   = 32;

    typedef enum int unsigned {
        SRC_TE      = 0,
        SRC_VS_RISE = 1,
        SRC_VS_FALL = 2,
        SRC_DE_RISE = 3,
        SRC_DE_FALL = 4,
        SRC_EOF     = 5
    } src_e;

    typedef logic [NSRC-1:0] src_vec_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    // Reserved positions are filled with zeros.
    function automatic logic [WORD_W-1:0] pack_word(src_vec_t stat, src_vec_t en);
        logic [WORD_W-1:0] w;
        w = '0;
        w[STAT_LSB +: NSRC] = stat;
        w[0 +: NSRC]        = en;
        return w;
    endfunction

endpackage

// File: rtl/vtev_edge_det.sv
module vtev_edge_det
    import vtev_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sig_i,
    output edge_t ev_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sig_i;
    end

    assign ev_o.rise = sig_i & ~prev_q;
    assign ev_o.fall = ~sig_i & prev_q;
endmodule

// File: rtl/vtev_te_sync.sv
module vtev_te_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic te_i,
    output logic te_rise_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= (sync_q << 1) | SYNC_STAGES'(te_i);
            last_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign te_rise_o = sync_q[SYNC_STAGES-1] & ~last_q;
endmodule

// File: rtl/vtev_eof_track.sv
module vtev_eof_track #(
    parameter int ACTIVE_LINES = 1080
) (
    input  logic clk,
    input  logic rst,
    input  logic vs_rise_i,
    input  logic de_fall_i,
    output logic eof_o
);
    localparam int CW = $clog2(ACTIVE_LINES + 1);
    localparam logic [CW-1:0] LAST = CW'(ACTIVE_LINES - 1);
    localparam logic [CW-1:0] SAT  = CW'(ACTIVE_LINES);

    logic [CW-1:0] line_q;

    always_ff @(posedge clk) begin
        if (rst)                          line_q <= '0;
        else if (vs_rise_i)               line_q <= '0;
        else if (de_fall_i && line_q != SAT) line_q <= line_q + 1'b1;
    end

    assign eof_o = de_fall_i && !vs_rise_i && (line_q == LAST);
endmodule

// File: rtl/vtev_stat_reg.sv
module vtev_stat_reg
    import vtev_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t evt_i,
    input  logic     wr_i,
    input  src_vec_t wr_en_i,
    input  src_vec_t wr_clr_i,
    output src_vec_t stat_o,
    output src_vec_t en_o,
    output logic     irq_o
);
    src_vec_t stat_q, en_q, clr_mask;

    assign clr_mask = wr_i ? wr_clr_i : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            en_q   <= '0;
        end else begin
            if (wr_i) en_q <= wr_en_i;
            stat_q <= (stat_q & ~clr_mask) | evt_i;
        end
    end

    assign stat_o = stat_q;
    assign en_o   = en_q;
    assign irq_o  = |(stat_q & en_q);
endmodule

// File: rtl/vtev_irq_ctrl.sv
module vtev_irq_ctrl
    import vtev_pkg::*;
#(
    parameter int ACTIVE_LINES = 1080,
    parameter int SYNC_STAGES  = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        vid_de,
    input  logic        vid_vs,
    input  logic        te_async,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq_o
);
    edge_t    de_ev, vs_ev;
    logic     te_rise, eof;
    src_vec_t evt, stat, en;
    logic     unused_wbits;

    vtev_edge_det u_de_edge (.clk(clk), .rst(rst), .sig_i(vid_de), .ev_o(de_ev));
    vtev_edge_det u_vs_edge (.clk(clk), .rst(rst), .sig_i(vid_vs), .ev_o(vs_ev));

    vtev_te_sync #(.SYNC_STAGES(SYNC_STAGES)) u_te (
        .clk(clk), .rst(rst), .te_i(te_async), .te_rise_o(te_rise)
    );

    vtev_eof_track #(.ACTIVE_LINES(ACTIVE_LINES)) u_eof (
        .clk(clk), .rst(rst), .vs_rise_i(vs_ev.rise), .de_fall_i(de_ev.fall), .eof_o(eof)
    );

    always_comb begin
        evt              = '0;
        evt[SRC_TE]      = te_rise;
        evt[SRC_VS_RISE] = vs_ev.rise;
        evt[SRC_VS_FALL] = vs_ev.fall;
        evt[SRC_DE_RISE] = de_ev.rise;
        evt[SRC_DE_FALL] = de_ev.fall;
        evt[SRC_EOF]     = eof;
    end

    vtev_stat_reg u_reg (
        .clk(clk), .rst(rst), .evt_i(evt), .wr_i(reg_wr),
        .wr_en_i(reg_wdata[0 +: NSRC]), .wr_clr_i(reg_wdata[STAT_LSB +: NSRC]),
        .stat_o(stat), .en_o(en), .irq_o(irq_o)
    );

    assign reg_rdata    = pack_word(stat, en);
    assign unused_wbits = ^{reg_wdata[31:22], reg_wdata[15:6]};
endmodule

// File: rtl/vtev_irq_ctrl_chk.sv
module vtev_irq_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic        vid_de,
    input logic        vid_vs,
    input logic        reg_wr,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic        irq_o
);
    logic unused_chk;
    assign unused_chk = ^reg_wdata[31:6];

    a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (reg_rdata == 32'h0 && !irq_o));

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[31:22] == 10'h0 && reg_rdata[15:6] == 10'h0));

    a_r2_enable_load: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> (reg_rdata[5:0] == $past(reg_wdata[5:0])));

    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        !reg_wr |=> ((reg_rdata[21:16] & $past(reg_rdata[21:16])) == $past(reg_rdata[21:16])));

    a_r3_vs_rise: assert property (@(posedge clk) disable iff (rst)
        (vid_vs && !$past(vid_vs) && !$past(rst)) |=> reg_rdata[17]);

    a_r4_de_fall: assert property (@(posedge clk) disable iff (rst)
        (!vid_de && $past(vid_de) && !$past(rst)) |=> reg_rdata[20]);

    a_r10_irq_level: assert property (@(posedge clk) disable iff (rst)
        irq_o == |(reg_rdata[21:16] & reg_rdata[5:0]));
endmodule

bind vtev_irq_ctrl vtev_irq_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .vid_de(vid_de), .vid_vs(vid_vs), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
);

// File: tb/vtev_irq_ctrl_tb.sv
`timescale 1ns/1ps
module vtev_irq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        vid_de = 1'b0, vid_vs = 1'b0, te_async = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        irq_o;
    int          checks = 0, errors = 0;
    logic        done = 1'b0;

    always #10 clk = ~clk;

    vtev_irq_ctrl #(.ACTIVE_LINES(2)) u_dut (
        .clk(clk), .rst(rst), .vid_de(vid_de), .vid_vs(vid_vs), .te_async(te_async),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [31:0] d);
        reg_wr = 1'b1; reg_wdata = d;
        tick();
        reg_wr = 1'b0; reg_wdata = 32'h0;
    endtask

    function automatic logic [31:0] word(logic [5:0] clr, logic [5:0] en);
        return {10'h0, clr, 10'h0, en};
    endfunction

    task automatic frame();
        vid_vs = 1'b1; tick();
        vid_vs = 1'b0; tick();
        te_async = 1'b1; tick();
        vid_de = 1'b1; tick(2); vid_de = 1'b0; tick(2);
        vid_de = 1'b1; tick(2); vid_de = 1'b0; tick(2);
        te_async = 1'b0; tick(3);
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick();
        chk("R1 rdata", reg_rdata, 32'h0);
        chk("R1 irq", {31'h0, irq_o}, 32'h0);

        // R2: every enable pattern, with ones written to reserved bits
        for (int e = 0; e < 64; e++) begin
            wr(32'hFFC0_FFC0 | 32'(e));
            chk("R2 enable readback", reg_rdata, 32'(e));
        end
        wr(32'h0);

        // R3, R4, R7: edges latch with all enables off
        vid_vs = 1'b1; tick();
        chk("R3 vs rise bit17", reg_rdata, 32'h0002_0000);
        chk("R7 irq off when disabled", {31'h0, irq_o}, 32'h0);
        vid_vs = 1'b0; tick();
        chk("R3 vs fall bit18", reg_rdata, 32'h0006_0000);
        vid_de = 1'b1; tick();
        chk("R4 de rise bit19", reg_rdata, 32'h000E_0000);
        vid_de = 1'b0; tick();
        chk("R4 de fall bit20", reg_rdata, 32'h001E_0000);

        // R8: write-1-to-clear
        wr(word(6'b000010, 6'h0));
        chk("R8 clear bit17 only", reg_rdata, 32'h001C_0000);
        wr(word(6'h00, 6'h0));
        chk("R8 zero write keeps", reg_rdata, 32'h001C_0000);
        wr(word(6'h3F, 6'h0));
        chk("R8 clear all", reg_rdata, 32'h0);

        // R11: steady high level does not re-set
        vid_vs = 1'b1; tick();
        wr(word(6'h3F, 6'h0));
        tick(3);
        chk("R11 level ignored", reg_rdata, 32'h0);
        vid_vs = 1'b0; tick();
        chk("R3 vs fall after hold", reg_rdata, 32'h0004_0000);
        wr(word(6'h3F, 6'h0));

        // R5: end of frame on the second line's DE fall
        vid_vs = 1'b1; tick(); vid_vs = 1'b0; tick();
        vid_de = 1'b1; tick(2); vid_de = 1'b0; tick();
        chk("R5 no eof line1", reg_rdata & 32'h0020_0000, 32'h0);
        vid_de = 1'b1; tick(2); vid_de = 1'b0; tick();
        chk("R5 eof line2", reg_rdata & 32'h0020_0000, 32'h0020_0000);
        wr(word(6'h3F, 6'h0));
        vid_de = 1'b1; tick(2); vid_de = 1'b0; tick();
        chk("R5 no eof line3", reg_rdata & 32'h0020_0000, 32'h0);
        wr(word(6'h3F, 6'h0));

        // R6: synchronised TE, visible after three edges
        te_async = 1'b1; tick(2);
        chk("R6 te not yet", reg_rdata, 32'h0);
        tick();
        chk("R6 te bit16", reg_rdata, 32'h0001_0000);
        wr(word(6'h3F, 6'h0));
        tick(3);
        chk("R11 te level ignored", reg_rdata, 32'h0);
        te_async = 1'b0; tick(3);

        // R9: event and clear in the same cycle
        vid_de = 1'b1; tick(); vid_de = 1'b0; tick();
        chk("R9 setup", reg_rdata, 32'h0018_0000);
        vid_de = 1'b1; reg_wr = 1'b1; reg_wdata = word(6'b011000, 6'h0);
        tick();
        reg_wr = 1'b0; reg_wdata = 32'h0;
        chk("R9 event wins", reg_rdata, 32'h0008_0000);
        vid_de = 1'b0; tick();
        wr(word(6'h3F, 6'h0));

        // R10: fire all sources, sweep clear masks with varied enables
        for (int m = 0; m < 64; m++) begin
            logic [5:0] en, left;
            frame();
            chk("R7 all six latched", reg_rdata, 32'h003F_0000 | 32'(reg_rdata[5:0]));
            en   = 6'((m * 7 + 3) & 63);
            left = ~6'(m);
            wr(word(6'(m), en));
            chk("R8 sweep status", reg_rdata, word(left, en));
            chk("R10 sweep irq", {31'h0, irq_o}, {31'h0, |(left & en)});
            wr(word(6'h3F, en));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule